// File: doc/BRIEF.md
# Serial flash write-enable command front end

This block sits on the serial-bus side of a flash memory device and owns the write-enable latch. The serial clock, active-low chip select and serial data input arrive asynchronously. They are brought into the system clock domain through a chain of synchronising flops, and their edges are found there. While chip select is low, data bits are captured on each rising edge of the serial clock, most significant bit first, and the first 8 bits form the instruction code.

When chip select rises, the block decides what the frame meant. A frame of exactly 8 bits carrying the set-enable code arms the latch, and one carrying the clear-enable code disarms it. A write-class code (program, erase, bulk erase or status write), received with at least 8 bits, is passed on to a downstream array engine only if the latch is already armed. The hand-off is a one-cycle start pulse with the code alongside it. The engine answers with a one-cycle done pulse, and that pulse disarms the latch.

The latch state is exported for a status read path. The serial output enable is raised only during a status read frame.

Top module: `sfwe_top`

## Requirements
- R1: After reset, `wel_o`, `eng_start_o` and `so_oe_o` are all 0.
- R2: A frame of exactly 8 bits with code 0x06 sets `wel_o` to 1. The change happens only after chip select rises; `wel_o` does not change while chip select is still low.
- R3: A frame of exactly 8 bits with code 0x04 clears `wel_o` to 0 at chip select rise.
- R4: A frame carrying code 0x06 or 0x04 is discarded when chip select rises after any bit count other than 8 (for example 0, 7 or 9). `wel_o` keeps its previous value.
- R5: A frame whose first 8 bits are 0x02, 0xD8, 0xC7 or 0x01 and that has at least 8 bits is a write-class frame. If `wel_o` is 1 at chip select rise, `eng_start_o` is high for exactly one clock and `eng_op_o` carries the code. If `wel_o` is 0, no start pulse appears. Issuing a write-class frame does not change `wel_o`. A write-class frame with fewer than 8 bits gives no start pulse.
- R6: A one-cycle pulse on `eng_done_i` clears `wel_o` to 0.
- R7: A frame of 8 bits with any code other than 0x06, 0x04 or the write-class codes leaves `wel_o` unchanged and gives no start pulse.
- R8: `so_oe_o` is 1 only while chip select is low after the full 8-bit code 0x05 has been received. It is 0 during all other frames, including the 0x06 and 0x04 frames.
- R9: Bits are sampled on the rising serial clock edge, most significant bit first. Bits after the 8th do not alter the captured code, so the bit-reversed code 0x60 has no effect on `wel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| mosi_i | input | 1 | Serial data input |
| eng_done_i | input | 1 | One-cycle completion pulse from the array engine |
| eng_start_o | output | 1 | One-cycle start pulse to the array engine |
| eng_op_o | output | 8 | Write-class code handed to the engine |
| wel_o | output | 1 | Write-enable latch state |
| so_oe_o | output | 1 | Serial output enable |

## Verification
The bench builds the block with its defaults: an 8-bit code width, two synchronising stages and the four write-class codes. At that size every one of the 256 possible codes can be sent as a full frame with the latch both armed and disarmed. Every code-dependent decision is therefore exercised against an expected latch, start and output-enable value worked out in the bench. Short frames, long frames and empty frames of the enable codes and of a write-class code cover the bit-count boundaries on either side of 8.

// File: rtl/sfwe_pkg.sv
package sfwe_pkg;
   localparam int OPC_W = 8;
   typedef logic [OPC_W-1:0] opc_t;

   localparam opc_t OPC_ARM    = 8'h06;
   localparam opc_t OPC_DISARM = 8'h04;
   localparam opc_t OPC_STATUS = 8'h05;
   localparam int   N_WRITE    = 4;
   localparam logic [N_WRITE-1:0][OPC_W-1:0] WRITE_OPCS =
      {8'h02, 8'hD8, 8'hC7, 8'h01};

   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_ARM   = 3'd1,
      CLS_DIS   = 3'd2,
      CLS_WRITE = 3'd3,
      CLS_READ  = 3'd4
   } cls_e;
endpackage

// File: rtl/sfwe_sync.sv
module sfwe_sync #(
   parameter int STAGES = 2,
   parameter int W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfwe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0] prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign sync_o = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sfwe_shift.sv
module sfwe_shift #(
   parameter int CODE_W = 8,
   localparam int CNT_MAX = CODE_W + 1,
   localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start_i,
   input  logic              bit_stb_i,
   input  logic              bit_i,
   output logic [CODE_W-1:0] code_o,
   output logic [CNT_W-1:0]  count_o
);
   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("sfwe_shift: CODE_W must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  count_q;
   logic              room;

   assign room = (count_q < CNT_W'(CODE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         count_q <= '0;
      end else if (frame_start_i) begin
         code_q  <= '0;
         count_q <= '0;
      end else if (bit_stb_i) begin
         if (room) code_q <= {code_q[CODE_W-2:0], bit_i};
         if (count_q != CNT_W'(CNT_MAX)) count_q <= count_q + 1'b1;
      end
   end

   assign code_o  = code_q;
   assign count_o = count_q;

   // R9: once the code is full, later bits leave it alone
   assert_code_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q >= CNT_W'(CODE_W) && !frame_start_i) |=> $stable(code_q));
endmodule

// File: rtl/sfwe_decode.sv
module sfwe_decode
   import sfwe_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter logic [CODE_W-1:0] ARM_CODE = OPC_ARM,
   parameter logic [CODE_W-1:0] DIS_CODE = OPC_DISARM,
   parameter logic [CODE_W-1:0] RD_CODE  = OPC_STATUS,
   parameter int NW = N_WRITE,
   parameter logic [NW-1:0][CODE_W-1:0] WR_CODES = WRITE_OPCS,
   localparam int CNT_W = $clog2(CODE_W + 2)
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [CNT_W-1:0]  count_i,
   output cls_e              cls_o
);
   generate
      if (NW < 1) begin : g_bad_list
         $error("sfwe_decode: at least one write-class code is required");
      end
   endgenerate

   logic [NW-1:0] wr_hit;
   logic exact, enough;

   generate
      for (genvar i = 0; i < NW; i++) begin : g_wr
         assign wr_hit[i] = (code_i == WR_CODES[i]);
      end
   endgenerate

   assign exact  = (count_i == CNT_W'(CODE_W));
   assign enough = (count_i >= CNT_W'(CODE_W));

   always_comb begin
      cls_o = CLS_NONE;
      if (exact && code_i == ARM_CODE)      cls_o = CLS_ARM;
      else if (exact && code_i == DIS_CODE) cls_o = CLS_DIS;
      else if (enough && |wr_hit)           cls_o = CLS_WRITE;
      else if (enough && code_i == RD_CODE) cls_o = CLS_READ;
   end
endmodule

// File: rtl/sfwe_latch.sv
module sfwe_latch
   import sfwe_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  cls_e              cls_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              done_i,
   output logic              wel_o,
   output logic              start_o,
   output logic [CODE_W-1:0] op_o
);
   logic              wel_q, start_q;
   logic [CODE_W-1:0] op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q   <= 1'b0;
         start_q <= 1'b0;
         op_q    <= '0;
      end else begin
         start_q <= 1'b0;
         if (done_i) begin
            wel_q <= 1'b0;
         end else if (commit_i) begin
            if (cls_i == CLS_ARM)      wel_q <= 1'b1;
            else if (cls_i == CLS_DIS) wel_q <= 1'b0;
         end
         if (commit_i && cls_i == CLS_WRITE && wel_q) begin
            start_q <= 1'b1;
            op_q    <= code_i;
         end
      end
   end

   assign wel_o   = wel_q;
   assign start_o = start_q;
   assign op_o    = op_q;

   // R5: a start pulse needs an armed latch
   assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(wel_q));
   // R5: start lasts one cycle
   assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   // R6: completion disarms the latch
   assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !wel_q);
   // R2: the latch arms only on a committed arm frame
   assert_arm_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(commit_i && cls_i == CLS_ARM));
endmodule

// File: rtl/sfwe_top.sv
module sfwe_top
   import sfwe_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CODE_W = OPC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              csn_i,
   input  logic              mosi_i,
   input  logic              eng_done_i,
   output logic              eng_start_o,
   output logic [CODE_W-1:0] eng_op_o,
   output logic              wel_o,
   output logic              so_oe_o
);
   localparam int CNT_W = $clog2(CODE_W + 2);

   generate
      if (CODE_W != OPC_W) begin : g_bad_code_w
         $error("sfwe_top: CODE_W must match the code table width");
      end
   endgenerate

   logic [2:0] pin_sync, pin_rise, pin_fall;
   logic sclk_rise, cs_low, cs_rise, cs_fall, mosi_s;
   logic [CODE_W-1:0] code;
   logic [CNT_W-1:0]  count;
   cls_e cls;
   logic oe_q;

   sfwe_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .async_i({mosi_i, csn_i, sclk_i}),
      .sync_o(pin_sync), .rise_o(pin_rise), .fall_o(pin_fall)
   );

   assign sclk_rise = pin_rise[0];
   assign cs_low    = ~pin_sync[1];
   assign cs_rise   = pin_rise[1];
   assign cs_fall   = pin_fall[1];
   assign mosi_s    = pin_sync[2];

   sfwe_shift #(.CODE_W(CODE_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .frame_start_i(cs_fall),
      .bit_stb_i(sclk_rise & cs_low),
      .bit_i(mosi_s),
      .code_o(code), .count_o(count)
   );

   sfwe_decode #(.CODE_W(CODE_W)) u_decode (
      .code_i(code), .count_i(count), .cls_o(cls)
   );

   sfwe_latch #(.CODE_W(CODE_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .commit_i(cs_rise), .cls_i(cls), .code_i(code),
      .done_i(eng_done_i),
      .wel_o(wel_o), .start_o(eng_start_o), .op_o(eng_op_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= cs_low && !cs_fall && (cls == CLS_READ);
   end

   assign so_oe_o = oe_q;

   // R8: output enable only inside a selected frame
   assert_oe_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> $past(cs_low));
   // R8: enable frames never drive output
   assert_oe_not_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> !(code == OPC_ARM || code == OPC_DISARM));
endmodule

// File: tb/sfwe_top_bench.sv
module sfwe_top_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, done = 1'b0;
   logic start, wel, oe;
   logic [7:0] op;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int start_cnt = 0;
   int oe_cnt = 0;
   logic [7:0] last_op = 8'h00;

   localparam int HALF = 4;

   always #4 clk = ~clk;

   sfwe_top u_sfwe_top (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
      .eng_done_i(done), .eng_start_o(start), .eng_op_o(op),
      .wel_o(wel), .so_oe_o(oe)
   );

   always @(negedge clk) begin
      cycles++;
      if (start) begin
         start_cnt++;
         last_op = op;
      end
      if (oe) oe_cnt++;
      if (cycles > 190000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   logic wel_before_rise;

   task automatic frame(input logic [7:0] code, input int nbits);
      start_cnt = 0;
      oe_cnt = 0;
      @(negedge clk);
      csn = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 8) ? code[7-i] : 1'b0;
         sclk = 1'b0;
         wait_clk(HALF);
         sclk = 1'b1;
         wait_clk(HALF);
      end
      sclk = 1'b0;
      wait_clk(HALF + 4);
      wel_before_rise = wel;
      csn = 1'b1;
      wait_clk(8);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      wait_clk(2);
   endtask

   function automatic bit is_wr(input logic [7:0] c);
      return c == 8'h02 || c == 8'hD8 || c == 8'hC7 || c == 8'h01;
   endfunction

   initial begin
      wait_clk(3);
      // R1: reset state
      check("R1 wel", int'(wel), 0);
      check("R1 start", int'(start), 0);
      check("R1 oe", int'(oe), 0);
      rst_n = 1'b1;
      wait_clk(4);
      check("R1 wel after release", int'(wel), 0);

      // R2: arm, no change before chip select rises
      frame(8'h06, 8);
      check("R2 wel before cs rise", int'(wel_before_rise), 0);
      check("R2 wel after cs rise", int'(wel), 1);
      check("R8 oe during arm frame", oe_cnt, 0);
      // R3: disarm
      frame(8'h04, 8);
      check("R3 wel before cs rise", int'(wel_before_rise), 1);
      check("R3 wel cleared", int'(wel), 0);
      check("R8 oe during disarm frame", oe_cnt, 0);

      // R4: wrong bit counts
      frame(8'h06, 7);  check("R4 arm 7 bits", int'(wel), 0);
      frame(8'h06, 9);  check("R4 arm 9 bits", int'(wel), 0);
      frame(8'h06, 0);  check("R4 arm 0 bits", int'(wel), 0);
      frame(8'h06, 8);
      frame(8'h04, 7);  check("R4 disarm 7 bits", int'(wel), 1);
      frame(8'h04, 9);  check("R4 disarm 9 bits", int'(wel), 1);

      // R5: long write frame accepted, short one ignored
      frame(8'hD8, 32);
      check("R5 long write start", start_cnt, 1);
      check("R5 long write op", int'(last_op), 8'hD8);
      check("R5 wel held", int'(wel), 1);
      frame(8'h02, 7);
      check("R5 short write no start", start_cnt, 0);
      pulse_done();
      check("R6 done clears", int'(wel), 0);

      // R9: bit-reversed arm code has no effect
      frame(8'h60, 8);
      check("R9 reversed code", int'(wel), 0);

      // R8: status read drives output enable, then drops
      frame(8'h05, 16);
      check("R8 oe in status frame", int'(oe_cnt > 0), 1);
      check("R8 oe after cs high", int'(oe), 0);

      // Exhaustive sweep of codes in both latch states
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < 256; c++) begin
            int exp_wel, exp_start, exp_oe;
            frame((s == 1) ? 8'h06 : 8'h04, 8);
            frame(8'(c), 8);
            exp_wel = (c == 8'h06) ? 1 : (c == 8'h04) ? 0 : s;
            exp_start = (is_wr(8'(c)) && s == 1) ? 1 : 0;
            exp_oe = (c == 8'h05) ? 1 : 0;
            if (is_wr(8'(c)))
               check($sformatf("R5 code %02h wel %0d start", c, s), start_cnt, exp_start);
            else
               check($sformatf("R7 code %02h wel %0d start", c, s), start_cnt, 0);
            if (c == 8'h06)
               check($sformatf("R2 sweep wel %0d", s), int'(wel), exp_wel);
            else if (c == 8'h04)
               check($sformatf("R3 sweep wel %0d", s), int'(wel), exp_wel);
            else
               check($sformatf("R7 code %02h wel %0d latch", c, s), int'(wel), exp_wel);
            check($sformatf("R8 code %02h oe", c), int'(oe_cnt > 0), exp_oe);
            if (exp_start == 1) begin
               check($sformatf("R5 code %02h op", c), int'(last_op), c);
               pulse_done();
               check($sformatf("R6 code %02h done clears", c), int'(wel), 0);
            end
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule